// File: doc/BRIEF.md
# Handshaked Random Word Generator

This block is the front end of an on-chip random source. Software controls it through a request/acknowledge handshake. A control register holds five request bits, one for each operation: instantiate, reseed, self-test, deterministic output and raw-entropy output. When a request is pending, the hardware runs that operation to completion and then sets the acknowledge bit at the same position in a state register. An acknowledge stays set until software writes a one to it. Writes to the control register carry a per-bit write-enable mask in their upper half, so software can change one request bit without a read-modify-write.

The deterministic generator is a 32-bit shift register with linear feedback. It stands in for a real cryptographic construction. The instantiate operation seeds it from the `entropy_i` input, and the reseed operation mixes `entropy_i` into its current state. The two output operations refresh an eight-word result buffer before they raise their acknowledge. The result buffer reads as zero unless one of the two output acknowledges is set. Clearing a request bit while its operation is still running abandons the operation and returns the block to idle.

Top module: `rng_reqack_top`

## Requirements
- R1: A write to offset 0x10 updates control bit i (0..15) with wdata[i] only where wdata[16+i] is 1. The control register reads back its 16 low bits, and its upper half reads as zero.
- R2: The request bits at offset 0x10 and the acknowledge bits at offset 0x14 share positions: bit 0 instantiate, bit 1 reseed, bit 2 self-test, bit 3 deterministic output, bit 4 entropy output. Result word k (k = 0..7) is read at 0x70+4k.
- R3: An acknowledge bit is set only when its operation completes. It stays set until a write to 0x14 carries a 1 at its position. Such a write leaves the other acknowledge bits untouched.
- R4: A request whose acknowledge is set is ignored. The operation does not run again and the buffer does not change. Once that acknowledge is cleared while the request is still set, the operation runs again.
- R5: Operations run one at a time. When several requests are pending, the lowest-numbered one runs first: instantiate, then reseed, then self-test, then deterministic output, then entropy output.
- R6: The deterministic output operation steps the generator eight times, with one step defined as x' = {x[30:0], parity(x & 32'h8020_0003)}. Word k receives the state after step k+1. The acknowledge rises only after all eight words are written.
- R7: After reset the generator state is 32'h1ACE_B00C. A deterministic output request made before any instantiate completes from that state.
- R8: Instantiate sets the state to entropy|1. Reseed sets it to (state XOR entropy)|1. Self-test changes neither the state nor the buffer.
- R9: The entropy output operation writes the value on `entropy_i` into each of the eight words, one word per cycle.
- R10: A result-word read returns zero unless acknowledge bit 3 or bit 4 is set.
- R11: Clearing a request bit while its operation runs cancels it. No acknowledge is raised and the block goes idle.
- R12: After reset the control register, the state register and all result words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| entropy_i | input | 32 | Entropy sample for seeding and for raw output |

## Verification
A wrong generator state does not show up as a status flag. It shows in the result words read after the next deterministic-output acknowledge, so every such run is compared word by word against a model that carries the state forward across operations. A fault in the arbiter or in the acknowledge logic shows within a few cycles of a write: the state register holds the wrong first nonzero value, or an acknowledge fails to hold. A buffer that refreshes when it should not shows as word values that change while the acknowledge stays set.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int NUM_OPS = 5;

  typedef enum logic [2:0] {
    OP_INST   = 3'd0,
    OP_RESEED = 3'd1,
    OP_TEST   = 3'd2,
    OP_DRNG   = 3'd3,
    OP_TRNG   = 3'd4
  } op_e;

  typedef enum logic {SEQ_IDLE, SEQ_BUSY} seq_e;

  localparam logic [7:0] CTRL_OFS = 8'h10;
  localparam logic [7:0] STAT_OFS = 8'h14;
  localparam logic [7:0] DATA_OFS = 8'h70;
endpackage

// File: rtl/rng_arbiter.sv
module rng_arbiter #(
  parameter int N = 5
) (
  input  logic [N-1:0] pend_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_prio
    assign gnt_o[i]     = pend_i[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | pend_i[i];
  end

  assign any_o = blocked[N];
endmodule

// File: rtl/rng_sequencer.sv
module rng_sequencer
  import rng_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int OP_LAT    = 4,
  localparam int MAXLEN   = (NUM_WORDS > OP_LAT) ? NUM_WORDS : OP_LAT,
  localparam int CW       = (MAXLEN > 2) ? $clog2(MAXLEN) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_OPS-1:0] req_i,
  input  logic [NUM_OPS-1:0] ack_i,
  output logic               step_en_o,
  output op_e                op_o,
  output logic [CW-1:0]      step_o,
  output logic [NUM_OPS-1:0] done_o
);
  seq_e          st_q;
  op_e           op_q, pick;
  logic [CW-1:0] cnt_q;
  logic [NUM_OPS-1:0] gnt;
  logic          any, data_op, last, live;

  rng_arbiter #(.N(NUM_OPS)) u_arb (
    .pend_i (req_i & ~ack_i),
    .gnt_o  (gnt),
    .any_o  (any)
  );

  always_comb begin
    pick = OP_INST;
    for (int i = NUM_OPS - 1; i >= 0; i--)
      if (gnt[i]) pick = op_e'(i);
  end

  assign data_op = (op_q == OP_DRNG) || (op_q == OP_TRNG);
  assign last    = data_op ? (cnt_q == CW'(NUM_WORDS - 1)) : (cnt_q == CW'(OP_LAT - 1));
  assign live    = (st_q == SEQ_BUSY) && req_i[op_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_IDLE;
      op_q  <= OP_INST;
      cnt_q <= '0;
    end else if (st_q == SEQ_IDLE) begin
      if (any) begin
        st_q  <= SEQ_BUSY;
        op_q  <= pick;
        cnt_q <= '0;
      end
    end else if (!live || last) begin
      st_q <= SEQ_IDLE;   // finished or cancelled
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign step_en_o = live;
  assign op_o      = op_q;
  assign step_o    = cnt_q;
  assign done_o    = (live && last) ? (NUM_OPS'(1) << op_q) : '0;

  AST_BUSY_OP_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SEQ_BUSY) |-> (int'(op_q) < NUM_OPS)); // R5
endmodule

// File: rtl/rng_gen.sv
module rng_gen
  import rng_pkg::*;
#(
  parameter int              DW         = 32,
  parameter int              NUM_WORDS  = 8,
  parameter int              CW         = 3,
  parameter logic [DW-1:0]   TAPS       = 32'h8020_0003,
  parameter logic [DW-1:0]   RESET_SEED = 32'h1ACE_B00C,
  localparam int             IW         = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           en_i,
  input  op_e                            op_i,
  input  logic [CW-1:0]                  idx_i,
  input  logic [DW-1:0]                  entropy_i,
  output logic [NUM_WORDS-1:0][DW-1:0]   words_o
);
  logic [DW-1:0] state_q, nxt;
  logic [NUM_WORDS-1:0][DW-1:0] words_q;
  logic [IW-1:0] widx;

  assign nxt  = {state_q[DW-2:0], ^(state_q & TAPS)};
  assign widx = idx_i[IW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RESET_SEED;
      words_q <= '0;
    end else if (en_i) begin
      unique case (op_i)
        OP_INST:   if (idx_i == '0) state_q <= entropy_i | DW'(1);
        OP_RESEED: if (idx_i == '0) state_q <= (state_q ^ entropy_i) | DW'(1);
        OP_DRNG: begin
          state_q       <= nxt;
          words_q[widx] <= nxt;
        end
        OP_TRNG:   words_q[widx] <= entropy_i;
        default: ;
      endcase
    end
  end

  assign words_o = words_q;

  AST_STATE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0); // R6
endmodule

// File: rtl/rng_reqack_top.sv
module rng_reqack_top
  import rng_pkg::*;
#(
  parameter int            DW         = 32,
  parameter int            AW         = 8,
  parameter int            NUM_WORDS  = 8,
  parameter int            OP_LAT     = 4,
  parameter logic [DW-1:0] TAPS       = 32'h8020_0003,
  parameter logic [DW-1:0] RESET_SEED = 32'h1ACE_B00C
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] entropy_i
);
  localparam int HW     = DW / 2;
  localparam int MAXLEN = (NUM_WORDS > OP_LAT) ? NUM_WORDS : OP_LAT;
  localparam int CW     = (MAXLEN > 2) ? $clog2(MAXLEN) : 1;
  localparam int IW     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic [HW-1:0]       ctrl_q;
  logic [NUM_OPS-1:0]  ack_q, clr_vec, done;
  logic                step_en;
  op_e                 op;
  logic [CW-1:0]       step;
  logic [NUM_WORDS-1:0][DW-1:0] words;
  logic [AW-1:0]       doff;
  logic                data_hit, data_ok;
  logic                unused_wdata;

  assign unused_wdata = ^wdata_i[HW-1:NUM_OPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_i && addr_i == AW'(CTRL_OFS)) begin
      for (int i = 0; i < HW; i++)
        if (wdata_i[HW+i]) ctrl_q[i] <= wdata_i[i];
    end
  end

  assign clr_vec = (wr_i && addr_i == AW'(STAT_OFS)) ? wdata_i[NUM_OPS-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= '0;
    else         ack_q <= (ack_q & ~clr_vec) | done;
  end

  rng_sequencer #(.NUM_WORDS(NUM_WORDS), .OP_LAT(OP_LAT)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (ctrl_q[NUM_OPS-1:0]),
    .ack_i     (ack_q),
    .step_en_o (step_en),
    .op_o      (op),
    .step_o    (step),
    .done_o    (done)
  );

  rng_gen #(.DW(DW), .NUM_WORDS(NUM_WORDS), .CW(CW), .TAPS(TAPS),
            .RESET_SEED(RESET_SEED)) u_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (step_en),
    .op_i      (op),
    .idx_i     (step),
    .entropy_i (entropy_i),
    .words_o   (words)
  );

  assign doff     = addr_i - AW'(DATA_OFS);
  assign data_hit = (doff < AW'(4 * NUM_WORDS)) && (doff[1:0] == 2'b00);
  assign data_ok  = ack_q[OP_DRNG] | ack_q[OP_TRNG];

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(CTRL_OFS))      rdata_o = DW'(ctrl_q);
    else if (addr_i == AW'(STAT_OFS)) rdata_o = DW'(ack_q);
    else if (data_hit && data_ok)     rdata_o = words[doff[IW+1:2]];
  end

  AST_ACK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ack_q & $past(ack_q & ~clr_vec)) == $past(ack_q & ~clr_vec))); // R3
  AST_ACK_ONLY_REQUESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ack_q & ~$past(ack_q) & ~$past(ctrl_q[NUM_OPS-1:0])) == '0)); // R11
  AST_ONE_ACK_AT_A_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $onehot0(ack_q & ~$past(ack_q))); // R5
  AST_WORDS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q[OP_DRNG] && !step_en) |=> $stable(words)); // R4
endmodule

// File: tb/test_rng_reqack_top.sv
module test_rng_reqack_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TAPS = 32'h8020_0003;
  localparam logic [31:0] SEED = 32'h1ACE_B00C;

  logic        clk_i = 1'b0, rst_ni = 1'b0, wr_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, entropy_i = '0;
  logic [31:0] rdata_o;

  int checks = 0, failures = 0;
  logic [31:0] m_state;

  rng_reqack_top i_rng_reqack_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .entropy_i(entropy_i)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  initial begin
    repeat (20000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [31:0] lstep(input logic [31:0] x);
    return {x[30:0], ^(x & TAPS)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  task automatic wait_ack(input logic [31:0] m);
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      rd(8'h14, v);
      if ((v & m) == m) return;
    end
  endtask

  task automatic first_nonzero(output logic [31:0] v);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      rd(8'h14, v);
      if (v != 0) return;
    end
  endtask

  task automatic check_drng_words(input string req);
    logic [31:0] v;
    for (int k = 0; k < 8; k++) begin
      m_state = lstep(m_state);
      @(negedge clk_i);
      rd(8'h70 + 8'(4*k), v);
      chk(req, v, m_state);
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    @(negedge clk_i);
    rd(8'h10, v); chk("R12 ctrl", v, 0);
    rd(8'h14, v); chk("R12 state", v, 0);
    rd(8'h70, v); chk("R12 word0", v, 0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(8'h10, 32'h0000_FFE0);      // mask clear: no change
    rd(8'h10, v); chk("R1 masked write", v, 0);
    wr(8'h10, 32'h0020_0020);      // bit5 only, no request
    rd(8'h10, v); chk("R1 enabled bit", v, 32'h20);
    wr(8'h10, 32'h0020_0000);
    rd(8'h10, v); chk("R1 cleared bit", v, 0);
  endtask

  task automatic t_drng_preinst;
    logic [31:0] v;
    m_state = SEED;
    wr(8'h10, 32'h0008_0008);
    wait_ack(32'h08);
    rd(8'h14, v); chk("R2 drng ack pos", v, 32'h08);
    check_drng_words("R7 reset-seed word");
  endtask

  task automatic t_sticky;
    logic [31:0] v, w0;
    rd(8'h70, w0);
    repeat (30) @(negedge clk_i);
    rd(8'h14, v); chk("R3 ack held", v, 32'h08);
    rd(8'h70, v); chk("R4 no rerun", v, w0);
    wr(8'h14, 32'h08);             // ctrl still set: reruns
    wait_ack(32'h08);
    check_drng_words("R4 rerun word");
    wr(8'h10, 32'h0008_0000);
    wr(8'h14, 32'h08);
    rd(8'h14, v); chk("R3 w1c", v, 0);
    rd(8'h70, v); chk("R10 masked data", v, 0);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    entropy_i = 32'hC0DE_1234;
    wr(8'h10, 32'h001F_0009);
    first_nonzero(v); chk("R5 inst first", v, 32'h01);
    m_state = 32'hC0DE_1234 | 1;
    wait_ack(32'h08);
    rd(8'h14, v); chk("R5 both acked", v, 32'h09);
    check_drng_words("R8 inst word");
    wr(8'h10, 32'h001F_0000);
    wr(8'h14, 32'h01);
    rd(8'h14, v); chk("R3 partial w1c", v, 32'h08);
    wr(8'h14, 32'h08);
  endtask

  task automatic t_reseed_test;
    logic [31:0] v;
    entropy_i = 32'h5A5A_0F0F;
    wr(8'h10, 32'h001F_0006);
    first_nonzero(v); chk("R5 reseed before test", v, 32'h02);
    wait_ack(32'h04);
    rd(8'h14, v); chk("R2 reseed+test ack", v, 32'h06);
    m_state = (m_state ^ 32'h5A5A_0F0F) | 1;
    wr(8'h10, 32'h001F_0008);
    wait_ack(32'h08);
    check_drng_words("R8 reseed word");
    wr(8'h10, 32'h001F_0000);
    wr(8'h14, 32'h1F);
  endtask

  task automatic t_trng;
    logic [31:0] v;
    entropy_i = 32'hBEEF_0077;
    wr(8'h10, 32'h001F_0010);
    wait_ack(32'h10);
    rd(8'h14, v); chk("R2 trng ack pos", v, 32'h10);
    for (int k = 0; k < 8; k++) begin
      rd(8'h70 + 8'(4*k), v); chk("R9 trng word", v, 32'hBEEF_0077);
    end
    wr(8'h10, 32'h001F_0000);
    wr(8'h14, 32'h10);
    rd(8'h74, v); chk("R10 masked after clear", v, 0);
  endtask

  task automatic t_cancel;
    logic [31:0] v;
    wr(8'h10, 32'h0008_0008);
    repeat (3) @(negedge clk_i);
    wr(8'h10, 32'h0008_0000);
    repeat (20) @(negedge clk_i);
    rd(8'h14, v); chk("R11 no ack", v, 0);
    rd(8'h70, v); chk("R11 no data", v, 0);
    rd(8'h10, v); chk("R11 ctrl idle", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_mask();
    t_drng_preinst();
    t_sticky();
    t_priority();
    t_reseed_test();
    t_trng();
    t_cancel();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule